// File: doc/BRIEF.md
# Memory Region Access Checker

This block holds a parameterised set of protection entries and rules on every memory access presented to it. Each entry pairs a word-granular address register with an 8-bit configuration byte that sets read, write and execute permission, one of three address-matching encodings or "off", and a lock. The configuration bytes are packed one per entry into configuration words as wide as the register width, so a 32-bit build holds four entries per configuration word.

Each cycle a request supplies a byte address, an access kind, a privilege level and a flag telling whether machine-mode accesses are currently subject to the lower-privilege rules. All entries are compared in parallel. The lowest-numbered entry that covers the address decides the outcome. The allow/deny verdict, a hit flag and the index of the deciding entry are registered and appear one clock after the request. Software programs the entries through simple word write and read ports. A lock freezes an entry and, for a top-of-range entry, also freezes its lower bound.

Top module: `memprot_checker`

## Requirements
- R1: After reset every entry is off and its address is zero, and rsp_allow, rsp_hit and rsp_idx are 0. The verdict for a request shows on the outputs after the next rising edge. It is computed from the register contents that were in place before any write taking effect at that same edge.
- R2: Entry e's configuration byte is byte (e mod XLEN/8) of configuration word e/(XLEN/8). Within the byte, bit 0 = read, bit 1 = write, bit 2 = execute, bits 4:3 = match mode (0 off, 1 top-of-range, 2 four-byte, 3 aligned power-of-two) and bit 7 = lock. Bits 6:5 always read 0. Configuration and address registers read back what was written.
- R3: An entry whose mode field is 0 (off) matches no address.
- R4: In top-of-range mode, entry i covers bytes from addr[i-1]*4 up to addr[i]*4-1 inclusive. For entry 0 the lower bound is 0.
- R5: In four-byte mode, an entry covers exactly bytes addr*4 to addr*4+3.
- R6: In aligned power-of-two mode, with t = addr*4+3 the entry covers bytes t&(t+1) through t|(t+1).
- R7: When several entries cover the address, only the lowest-numbered one decides allow/deny, and its index appears on rsp_idx.
- R8: For user (req_priv 0) and supervisor (req_priv 1) requests, a hit is allowed only if the deciding entry has the permission bit for the access kind (req_kind 0 read, 1 write, 2 execute). A request that matches no entry is denied.
- R9: A machine-mode request (req_priv 3) with req_mprv clear is allowed when no entry matches, and also when the deciding entry is unlocked, whatever its permission bits.
- R10: A locked deciding entry enforces its permission bits on machine-mode requests too. A locked entry with no permission bits denies every access to its range.
- R11: A machine-mode request with req_mprv set follows the user/supervisor rules: unlocked hits enforce permissions and a miss is denied.
- R12: Writes to the configuration byte or the address register of a locked entry leave them unchanged. Unlocked bytes in the same configuration word are still written.
- R13: A write to address register i is ignored while entry i+1 is locked in top-of-range mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_widx | input | 2 | Configuration word index for the write |
| cfg_wdata | input | 32 | Configuration word write data |
| cfg_ridx | input | 2 | Configuration word index for the read |
| cfg_rdata | output | 32 | Configuration word read data (combinational) |
| addr_we | input | 1 | Address register write strobe |
| addr_widx | input | 4 | Entry index for the address write |
| addr_wdata | input | 32 | Address write data (byte address divided by four) |
| addr_ridx | input | 4 | Entry index for the address read |
| addr_rdata | output | 32 | Address register read data (combinational) |
| req_addr | input | 34 | Byte address of the access |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| req_mprv | input | 1 | Machine-mode accesses obey the lower-privilege rules |
| rsp_allow | output | 1 | Registered verdict: 1 allowed |
| rsp_hit | output | 1 | Registered: some entry matched |
| rsp_idx | output | 4 | Registered index of the deciding entry |

## Verification
A configuration write and an access check can land in the same cycle. The check must then be judged against the old entry set, and the new entry takes effect only from the following request. The bench raises a write that turns an entry on while it holds a request aimed at that entry's range. It expects a miss on the first verdict and a hit with the new index on the next. Lock protection and programming also meet: writes aimed at a locked entry, or at the lower bound of a locked top-of-range entry, are judged by reading the registers back and by unchanged verdicts, while unlocked bytes of the same word must still change.

// File: rtl/memprot_pkg.sv
`timescale 1ns/1ps
package memprot_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsv;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } ecfg_t;

    // Store a written byte with the reserved field forced to zero.
    function automatic ecfg_t cfg_legalize(input logic [7:0] b);
        ecfg_t c;
        c     = ecfg_t'(b);
        c.rsv = 2'b00;
        return c;
    endfunction

    // Permission bit that governs a given access kind.
    function automatic logic cfg_permits(input ecfg_t c, input acc_e k);
        logic p;
        case (k)
            ACC_READ:  p = c.r;
            ACC_WRITE: p = c.w;
            ACC_EXEC:  p = c.x;
            default:   p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/memprot_regs.sv
`timescale 1ns/1ps
module memprot_regs
    import memprot_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int XLEN  = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CREG_W-1:0]             cfg_widx,
    input  logic [XLEN-1:0]               cfg_wdata,
    input  logic [CREG_W-1:0]             cfg_ridx,
    output logic [XLEN-1:0]               cfg_rdata,
    input  logic                          addr_we,
    input  logic [IDX_W-1:0]              addr_widx,
    input  logic [XLEN-1:0]               addr_wdata,
    input  logic [IDX_W-1:0]              addr_ridx,
    output logic [XLEN-1:0]               addr_rdata,
    output ecfg_t [N_ENT-1:0]             ent_cfg,
    output logic [N_ENT-1:0][XLEN-1:0]    ent_addr
);
    localparam int PER_WORD = XLEN / 8;
    localparam int N_WORDS  = N_ENT / PER_WORD;
    localparam int CREG_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [N_WORDS-1:0][XLEN-1:0] cfg_words;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        localparam int WSEL = e / PER_WORD;
        localparam int BSEL = e % PER_WORD;

        ecfg_t           cfg_q;
        logic [XLEN-1:0] addr_q;
        logic            addr_guard;

        if (e + 1 < N_ENT) begin : g_guard
            assign addr_guard = ent_cfg[e+1].lock && (ent_cfg[e+1].mode == AM_TOR);
            // R13: lower bound of a locked top-of-range neighbour is frozen
            a_r13_tor_bound_frozen: assert property (@(posedge clk) disable iff (rst)
                $past(addr_guard) |-> $stable(addr_q));
        end else begin : g_last
            assign addr_guard = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q  <= '0;
                addr_q <= '0;
            end else begin
                if (cfg_we && cfg_widx == CREG_W'(WSEL) && !cfg_q.lock)
                    cfg_q <= cfg_legalize(cfg_wdata[BSEL*8 +: 8]);
                if (addr_we && addr_widx == IDX_W'(e) && !cfg_q.lock && !addr_guard)
                    addr_q <= addr_wdata;
            end
        end

        assign ent_cfg[e]                  = cfg_q;
        assign ent_addr[e]                 = addr_q;
        assign cfg_words[WSEL][BSEL*8 +: 8] = cfg_q;

        // R12: a locked entry keeps its configuration and address
        a_r12_locked_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
            $past(cfg_q.lock) |-> $stable(cfg_q));
        a_r12_locked_addr_frozen: assert property (@(posedge clk) disable iff (rst)
            $past(cfg_q.lock) |-> $stable(addr_q));
        // R2: reserved bits never become set
        a_r2_rsv_zero: assert property (@(posedge clk) disable iff (rst)
            cfg_q.rsv == 2'b00);
    end

    assign cfg_rdata  = cfg_words[cfg_ridx];
    assign addr_rdata = ent_addr[addr_ridx];

endmodule

// File: rtl/memprot_match.sv
`timescale 1ns/1ps
module memprot_match
    import memprot_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  amode_e          mode,
    input  logic [XLEN-1:0] lo_word,
    input  logic [XLEN-1:0] cur_word,
    input  logic [XLEN-1:0] req_word,
    output logic            hit
);
    // Word-level span mask of an aligned power-of-two region: the trailing
    // ones of the address plus the zero just above them.
    logic [XLEN-1:0] span_mask;
    assign span_mask = cur_word ^ (cur_word + XLEN'(1));

    always_comb begin
        case (mode)
            AM_TOR:   hit = (req_word >= lo_word) && (req_word < cur_word);
            AM_NA4:   hit = (req_word == cur_word);
            AM_NAPOT: hit = ((req_word ^ cur_word) & ~span_mask) == '0;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/memprot_decide.sv
`timescale 1ns/1ps
module memprot_decide
    import memprot_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_ENT-1:0]   hit_vec,
    input  ecfg_t [N_ENT-1:0]  ent_cfg,
    input  acc_e               kind,
    input  priv_e              priv,
    input  logic               mprv,
    output logic               rsp_allow,
    output logic               rsp_hit,
    output logic [IDX_W-1:0]   rsp_idx
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic             any_hit;
    ecfg_t            win_cfg;
    logic [IDX_W-1:0] win_idx;
    logic             enforce;
    logic             allow_d;

    // Lowest index wins: scan downward so the last assignment is the lowest hit.
    always_comb begin
        any_hit = 1'b0;
        win_cfg = '0;
        win_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_cfg = ent_cfg[i];
                win_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        enforce = (priv != PRIV_M) || mprv || win_cfg.lock;
        if (any_hit)
            allow_d = enforce ? cfg_permits(win_cfg, kind) : 1'b1;
        else
            allow_d = (priv == PRIV_M) && !mprv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_allow <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
        end else begin
            rsp_allow <= allow_d;
            rsp_hit   <= any_hit;
            rsp_idx   <= win_idx;
        end
    end

    // R9: machine mode without MPRV and no matching entry is granted
    a_r9_machine_default: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_vec == '0 && priv == PRIV_M && !mprv))
            |-> (rsp_allow && !rsp_hit));
    // R8 / R11: a miss in any other situation is refused
    a_r8_miss_denied: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_vec == '0 && (priv != PRIV_M || mprv)))
            |-> !rsp_allow);
    // R7: entry 0 outranks all others
    a_r7_entry0_wins: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_vec[0])) |-> (rsp_hit && rsp_idx == '0));
    // R10: locked entry 0 without permissions refuses every request
    a_r10_locked_none: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_vec[0] && ent_cfg[0].lock &&
                               !ent_cfg[0].r && !ent_cfg[0].w && !ent_cfg[0].x))
            |-> !rsp_allow);

endmodule

// File: rtl/memprot_checker.sv
`timescale 1ns/1ps
module memprot_checker
    import memprot_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int XLEN   = 32,
    localparam int CREG_W = ((N_ENT * 8 / XLEN) > 1) ? $clog2(N_ENT * 8 / XLEN) : 1,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int BA_W   = XLEN + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CREG_W-1:0] cfg_widx,
    input  logic [XLEN-1:0]   cfg_wdata,
    input  logic [CREG_W-1:0] cfg_ridx,
    output logic [XLEN-1:0]   cfg_rdata,
    input  logic              addr_we,
    input  logic [IDX_W-1:0]  addr_widx,
    input  logic [XLEN-1:0]   addr_wdata,
    input  logic [IDX_W-1:0]  addr_ridx,
    output logic [XLEN-1:0]   addr_rdata,
    input  logic [BA_W-1:0]   req_addr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_priv,
    input  logic              req_mprv,
    output logic              rsp_allow,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx
);
    ecfg_t [N_ENT-1:0]          ent_cfg;
    logic  [N_ENT-1:0][XLEN-1:0] ent_addr;
    logic  [N_ENT-1:0]          hit_vec;
    logic  [XLEN-1:0]           req_word;

    assign req_word = req_addr[BA_W-1:2];

    memprot_regs #(.N_ENT(N_ENT), .XLEN(XLEN)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_widx   (cfg_widx),
        .cfg_wdata  (cfg_wdata),
        .cfg_ridx   (cfg_ridx),
        .cfg_rdata  (cfg_rdata),
        .addr_we    (addr_we),
        .addr_widx  (addr_widx),
        .addr_wdata (addr_wdata),
        .addr_ridx  (addr_ridx),
        .addr_rdata (addr_rdata),
        .ent_cfg    (ent_cfg),
        .ent_addr   (ent_addr)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        logic [XLEN-1:0] lo_word;
        if (i == 0) begin : g_first
            assign lo_word = '0;
        end else begin : g_rest
            assign lo_word = ent_addr[i-1];
        end
        memprot_match #(.XLEN(XLEN)) u_match (
            .mode     (ent_cfg[i].mode),
            .lo_word  (lo_word),
            .cur_word (ent_addr[i]),
            .req_word (req_word),
            .hit      (hit_vec[i])
        );
    end

    memprot_decide #(.N_ENT(N_ENT)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .hit_vec   (hit_vec),
        .ent_cfg   (ent_cfg),
        .kind      (acc_e'(req_kind)),
        .priv      (priv_e'(req_priv)),
        .mprv      (req_mprv),
        .rsp_allow (rsp_allow),
        .rsp_hit   (rsp_hit),
        .rsp_idx   (rsp_idx)
    );

endmodule

// File: tb/sim_memprot_checker.sv
`timescale 1ns/1ps
module sim_memprot_checker;
    localparam int N_ENT = 16;
    localparam int XLEN  = 32;

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
    localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_widx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_ridx = '0;
    logic [31:0] cfg_rdata;
    logic        addr_we = 1'b0;
    logic [3:0]  addr_widx = '0;
    logic [31:0] addr_wdata = '0;
    logic [3:0]  addr_ridx = '0;
    logic [31:0] addr_rdata;
    logic [33:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_priv = '0;
    logic        req_mprv = 1'b0;
    logic        rsp_allow;
    logic        rsp_hit;
    logic [3:0]  rsp_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    memprot_checker #(.N_ENT(N_ENT), .XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wdata(cfg_wdata),
        .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
        .addr_we(addr_we), .addr_widx(addr_widx), .addr_wdata(addr_wdata),
        .addr_ridx(addr_ridx), .addr_rdata(addr_rdata),
        .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
        .req_mprv(req_mprv),
        .rsp_allow(rsp_allow), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rsp_is(input string tag, input logic ea, input logic eh, input int ei);
        chk({tag, " allow"}, 64'(rsp_allow), 64'(ea));
        chk({tag, " hit"}, 64'(rsp_hit), 64'(eh));
        if (eh) chk({tag, " idx"}, 64'(rsp_idx), 64'(ei));
    endtask

    task automatic wr_cfg(input int w, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_widx = w[1:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_addr(input int e, input logic [31:0] d);
        @(negedge clk);
        addr_we = 1'b1; addr_widx = e[3:0]; addr_wdata = d;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic rd_cfg(input string tag, input int w, input logic [31:0] exp);
        @(negedge clk);
        cfg_ridx = w[1:0];
        #1;
        chk(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic rd_addr(input string tag, input int e, input logic [31:0] exp);
        @(negedge clk);
        addr_ridx = e[3:0];
        #1;
        chk(tag, 64'(addr_rdata), 64'(exp));
    endtask

    // Present a request at a falling edge; sample just after the next rising edge.
    task automatic access(input logic [33:0] a, input logic [1:0] k,
                          input logic [1:0] p, input logic mp);
        @(negedge clk);
        req_addr = a; req_kind = k; req_priv = p; req_mprv = mp;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        #1;
        rsp_is("R1 reset outputs", 1'b0, 1'b0, 0);
        chk("R1 reset idx", 64'(rsp_idx), 64'd0);
        rd_cfg("R1 reset cfg word", 0, 32'h0);
        rd_addr("R1 reset addr", 5, 32'h0);
        access(34'h100, RD, PU, 1'b0);
        rsp_is("R1 user after reset", 1'b0, 1'b0, 0);
        access(34'h100, WR, PM, 1'b0);
        rsp_is("R1 machine after reset", 1'b1, 1'b0, 0);
    endtask

    task automatic t_layout;
        // word 3: entry12 0x00, entry13 0x05, entry14 0x0B, entry15 0x1A (power-of-two, W)
        wr_cfg(3, 32'h1A0B_0500);
        rd_cfg("R2 cfg readback", 3, 32'h1A0B_0500);
        wr_cfg(2, 32'h0000_0060);
        rd_cfg("R2 reserved bits read zero", 2, 32'h0);
        wr_addr(9, 32'hDEAD_BEEF);
        rd_addr("R2 addr readback", 9, 32'hDEAD_BEEF);
        // entry15 addr 0 -> words 0..1, bytes 0..7
        access(34'h4, WR, PU, 1'b0);
        rsp_is("R2 top byte is entry15", 1'b1, 1'b1, 15);
        access(34'h4, RD, PU, 1'b0);
        rsp_is("R2 entry15 lacks read", 1'b0, 1'b1, 15);
        wr_cfg(3, 32'h0);
        rd_cfg("R2 cfg cleared", 3, 32'h0);
    endtask

    task automatic t_tor_off;
        wr_addr(0, 32'h40);
        wr_addr(1, 32'h80);
        wr_cfg(0, 32'h0000_0B09);
        access(34'hFC, RD, PU, 1'b0);
        rsp_is("R4 entry0 top byte", 1'b1, 1'b1, 0);
        access(34'h10, WR, PU, 1'b0);
        rsp_is("R8 entry0 no write", 1'b0, 1'b1, 0);
        access(34'h100, WR, PU, 1'b0);
        rsp_is("R4 entry1 lower bound", 1'b1, 1'b1, 1);
        access(34'h1FF, RD, PU, 1'b0);
        rsp_is("R4 entry1 last byte", 1'b1, 1'b1, 1);
        access(34'h200, RD, PU, 1'b0);
        rsp_is("R4 past entry1 top", 1'b0, 1'b0, 0);
        wr_cfg(0, 32'h0000_0009);
        access(34'h180, RD, PU, 1'b0);
        rsp_is("R3 off entry ignored", 1'b0, 1'b0, 0);
        wr_cfg(0, 32'h0000_0B09);
    endtask

    task automatic t_na4;
        wr_addr(2, 32'h100);
        wr_cfg(0, 32'h0014_0B09);
        access(34'h403, EX, PU, 1'b0);
        rsp_is("R5 last byte", 1'b1, 1'b1, 2);
        access(34'h400, RD, PU, 1'b0);
        rsp_is("R8 execute-only read", 1'b0, 1'b1, 2);
        access(34'h404, EX, PU, 1'b0);
        rsp_is("R5 above range", 1'b0, 1'b0, 0);
        access(34'h3FF, EX, PU, 1'b0);
        rsp_is("R5 below range", 1'b0, 1'b0, 0);
    endtask

    task automatic t_napot;
        wr_addr(3, 32'h203);  // bytes 0x800..0x81F
        wr_cfg(0, 32'h1914_0B09);
        access(34'h800, RD, PU, 1'b0);
        rsp_is("R6 base", 1'b1, 1'b1, 3);
        access(34'h81F, RD, PU, 1'b0);
        rsp_is("R6 top", 1'b1, 1'b1, 3);
        access(34'h820, RD, PU, 1'b0);
        rsp_is("R6 above", 1'b0, 1'b0, 0);
        access(34'h7FF, RD, PU, 1'b0);
        rsp_is("R6 below", 1'b0, 1'b0, 0);
    endtask

    task automatic t_priority_modes;
        wr_addr(4, 32'h2FF);  // bytes 0x800..0xFFF, all permissions
        wr_cfg(1, 32'h0000_001F);
        access(34'h810, WR, PU, 1'b0);
        rsp_is("R7 lower entry decides", 1'b0, 1'b1, 3);
        access(34'h900, WR, PU, 1'b0);
        rsp_is("R7 outer entry", 1'b1, 1'b1, 4);
        access(34'h900, EX, PS, 1'b0);
        rsp_is("R8 supervisor hit", 1'b1, 1'b1, 4);
        access(34'h5000, RD, PS, 1'b0);
        rsp_is("R8 supervisor miss", 1'b0, 1'b0, 0);
        access(34'h810, WR, PM, 1'b0);
        rsp_is("R9 machine unlocked hit", 1'b1, 1'b1, 3);
        access(34'h5000, RD, PM, 1'b0);
        rsp_is("R9 machine miss", 1'b1, 1'b0, 0);
        access(34'h810, WR, PM, 1'b1);
        rsp_is("R11 mprv enforces", 1'b0, 1'b1, 3);
        access(34'h810, RD, PM, 1'b1);
        rsp_is("R11 mprv permitted", 1'b1, 1'b1, 3);
        access(34'h5000, RD, PM, 1'b1);
        rsp_is("R11 mprv miss", 1'b0, 1'b0, 0);
    endtask

    task automatic t_lock;
        wr_addr(5, 32'h1400);  // bytes 0x5000..0x5003
        wr_cfg(1, 32'h0000_901F);
        access(34'h5000, RD, PM, 1'b0);
        rsp_is("R10 locked none machine", 1'b0, 1'b1, 5);
        access(34'h5002, EX, PM, 1'b0);
        rsp_is("R10 locked none execute", 1'b0, 1'b1, 5);
        access(34'h5004, RD, PM, 1'b0);
        rsp_is("R10 outside locked", 1'b1, 1'b0, 0);
        wr_cfg(1, 32'h0000_001B);
        rd_cfg("R12 locked byte kept, other byte written", 1, 32'h0000_901B);
        wr_addr(5, 32'h0);
        rd_addr("R12 locked addr kept", 5, 32'h1400);
        access(34'h5000, RD, PM, 1'b0);
        rsp_is("R12 still denied", 1'b0, 1'b1, 5);
    endtask

    task automatic t_tor_guard;
        wr_addr(6, 32'h2000);
        wr_addr(7, 32'h2010);  // bytes 0x8000..0x803F
        wr_cfg(1, 32'h8900_901B);
        wr_addr(6, 32'h1000);
        rd_addr("R13 bound below locked TOR kept", 6, 32'h2000);
        wr_addr(7, 32'h3000);
        rd_addr("R12 locked TOR addr kept", 7, 32'h2010);
        access(34'h8000, WR, PM, 1'b0);
        rsp_is("R10 locked TOR no write", 1'b0, 1'b1, 7);
        access(34'h803C, RD, PM, 1'b0);
        rsp_is("R10 locked TOR read", 1'b1, 1'b1, 7);
        access(34'h8040, RD, PM, 1'b0);
        rsp_is("R13 TOR top intact", 1'b1, 1'b0, 0);
        access(34'h7FFC, RD, PU, 1'b0);
        rsp_is("R13 TOR base intact", 1'b0, 1'b0, 0);
        wr_addr(8, 32'h3000);
        rd_addr("R13 unguarded addr written", 8, 32'h3000);
    endtask

    task automatic t_same_cycle;
        // enable entry8 as four-byte read at 0xC000 in the cycle it is queried
        @(negedge clk);
        cfg_we = 1'b1; cfg_widx = 2'd2; cfg_wdata = 32'h0000_0011;
        req_addr = 34'hC000; req_kind = RD; req_priv = PU; req_mprv = 1'b0;
        @(posedge clk);
        #1;
        rsp_is("R1 same-cycle write unseen", 1'b0, 1'b0, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk);
        #1;
        rsp_is("R1 write seen next request", 1'b1, 1'b1, 8);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_layout();
        t_tor_off();
        t_na4();
        t_napot();
        t_priority_modes();
        t_lock();
        t_tor_guard();
        t_same_cycle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule